// File: doc/BRIEF.md
# I2C Quad DAC Register Front-End

This block is the digital control side of a four-channel, 12-bit digital-to-analog converter. It listens to a two-wire I2C bus as a slave and accepts write transfers of a fixed length. Each transfer has four bytes: the slave address byte, a command byte, and two code bytes. Every channel has an input register and a DAC register. A command can load the input registers, move them into the DAC registers, do both at once, or put channels into power-down.

A separate active-low load pin gives the host a second way to update the outputs. A falling edge on this pin moves all four input registers into the DAC registers at once, but only if a complete four-byte write has arrived since the last START. While the pin is held low, every channel is forced awake and power-down commands are refused. The block drives SDA only through an open-drain enable during acknowledge slots.

The bus has no back-pressure: the slave never stretches SCL. The DAC codes and power-down flags are level outputs with no valid/ready handshake. All inputs are synchronised to the system clock, which must run several times faster than SCL.

Top module: `dqf_front`

## Requirements
- R1: The address byte is acknowledged only when its upper seven bits equal `dev_addr` and bit 0 (read/write) is 0. In any other case that byte and every later byte up to the next START get no acknowledge, and no register changes.
- R2: After a matching address, the block acknowledges bytes 2 to 4 and does not acknowledge a fifth byte. The 12-bit code is byte 3 followed by bits 7:4 of byte 4. Bits 3:0 of byte 4 are ignored. The command takes effect once the fourth byte has been received.
- R3: Command byte bits 7:4 give the operation: 0 loads the input register, 1 copies the input register into the DAC register, 3 loads both with the code, and 4 sets power-down. Any other value changes nothing. Bits 3:0 pick channel 0 to 3. The value 15 picks all channels, and any other value picks none.
- R4: Operations 1 and 3 clear the power-down flag of each selected channel.
- R5: SDA is sampled on SCL rising edges. `sda_oe` is asserted only during acknowledge slots.
- R6: A falling edge of `ldac_n_i` that follows a complete four-byte write copies all four input registers into the DAC registers.
- R7: A falling edge of `ldac_n_i` does nothing when no complete write has been received since the last START or since the last load. A START or STOP before the fourth byte discards the partial transfer.
- R8: While `ldac_n_i` is low, `pwrdn_o` is all zero.
- R9: A power-down command that completes while `ldac_n_i` is low is ignored, and it stays ignored after the pin returns high.
- R10: After reset, all DAC codes are zero, all channels are powered up, and `sda_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_addr | input | 7 | Slave address this block answers to |
| scl_i | input | 1 | Bus clock as seen on the wire |
| sda_i | input | 1 | Bus data as seen on the wire (wired-AND) |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| ldac_n_i | input | 1 | Active-low asynchronous load / power-up pin |
| dac_code_o | output | 48 | Four DAC codes, channel c at bits [12c+11:12c] |
| pwrdn_o | output | 4 | Per-channel power-down flag, bit c for channel c |

## Verification
Timing is counted from the first clock edge after a pin changes. A command becomes visible on `dac_code_o` and `pwrdn_o` four edges after the SCL fall that ends the fourth byte: two synchroniser stages, the receiver register, then the register bank. A load-pin fall reaches `dac_code_o` after three edges, and the forced power-up on `pwrdn_o` appears after two. The acknowledge enable follows an SCL fall by three edges. The bench holds every bus phase for eight clocks, reads the acknowledge in the middle of the high phase, and compares outputs at least eight clocks after each stop or pin edge. Every sample is taken on a falling clock edge, so each result has settled before it is read.

// File: rtl/dqf_pkg.sv
package dqf_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned FRAME_BYTES = 4;
  localparam int unsigned CODE_W      = 12;
  localparam int unsigned LO_KEEP     = CODE_W - BYTE_W;

  localparam logic [3:0] OP_WRITE  = 4'h0;
  localparam logic [3:0] OP_UPDATE = 4'h1;
  localparam logic [3:0] OP_WRUPD  = 4'h3;
  localparam logic [3:0] OP_PWRDN  = 4'h4;
  localparam logic [3:0] CH_ALL    = 4'hF;

  typedef struct packed {
    logic [3:0] op;
    logic [3:0] ch;
  } cmd_t;

  typedef enum logic [1:0] {
    RX_IDLE,
    RX_RECV,
    RX_ACK,
    RX_SKIP
  } rx_state_e;
endpackage

// File: rtl/dqf_sync.sv
module dqf_sync #(
  parameter int unsigned WIDTH   = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/dqf_i2c_rx.sv
module dqf_i2c_rx
  import dqf_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic              scl_s,
  input  logic              sda_s,
  output logic              sda_oe,
  output logic              start_o,
  output logic              frame_done_o,
  output cmd_t              cmd_o,
  output logic [CODE_W-1:0] code_o
);
  localparam int unsigned BIDX_W = $clog2(FRAME_BYTES);
  localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(FRAME_BYTES - 1);
  localparam logic [3:0] BITS_PER_BYTE = 4'(BYTE_W);

  rx_state_e         state_q;
  logic              scl_q, sda_q;
  logic [3:0]        bit_cnt_q;
  logic [BIDX_W-1:0] byte_idx_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] cmd_q;
  logic [BYTE_W-1:0] hi_q;
  logic [LO_KEEP-1:0] lo_q;
  logic              done_q;

  logic scl_rise, scl_fall, start, stop, addr_hit;

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start    = scl_s & scl_q & sda_q & ~sda_s;
  assign stop     = scl_s & scl_q & ~sda_q & sda_s;
  assign addr_hit = (shreg_q[BYTE_W-1:1] == dev_addr) & ~shreg_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= RX_IDLE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      cmd_q      <= '0;
      hi_q       <= '0;
      lo_q       <= '0;
      done_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (start) begin
        state_q    <= RX_RECV;
        bit_cnt_q  <= '0;
        byte_idx_q <= '0;
      end else if (stop) begin
        state_q <= RX_IDLE;
      end else begin
        case (state_q)
          RX_RECV: begin
            if (scl_rise && bit_cnt_q < BITS_PER_BYTE) begin
              shreg_q   <= {shreg_q[BYTE_W-2:0], sda_s};
              bit_cnt_q <= bit_cnt_q + 4'd1;
            end else if (scl_fall && bit_cnt_q == BITS_PER_BYTE) begin
              if (byte_idx_q == '0) begin
                state_q <= addr_hit ? RX_ACK : RX_SKIP;
              end else begin
                state_q <= RX_ACK;
                if (byte_idx_q == BIDX_W'(1))      cmd_q <= shreg_q;
                else if (byte_idx_q == BIDX_W'(2)) hi_q  <= shreg_q;
                else                               lo_q  <= shreg_q[BYTE_W-1 -: LO_KEEP];
                if (byte_idx_q == LAST_IDX) done_q <= 1'b1;
              end
            end
          end
          RX_ACK: begin
            if (scl_fall) begin
              bit_cnt_q <= '0;
              if (byte_idx_q == LAST_IDX) begin
                state_q <= RX_SKIP;
              end else begin
                state_q    <= RX_RECV;
                byte_idx_q <= byte_idx_q + BIDX_W'(1);
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe       = (state_q == RX_ACK);
  assign start_o      = start;
  assign frame_done_o = done_q;
  assign cmd_o        = cmd_q;
  assign code_o       = {hi_q, lo_q};

  // R5
  ack_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> $past(scl_fall || start || stop));

  // R5
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (bit_cnt_q == BITS_PER_BYTE));

  // R2
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (byte_idx_q == LAST_IDX && state_q == RX_ACK));
endmodule

// File: rtl/dqf_regbank.sv
module dqf_regbank
  import dqf_pkg::*;
#(
  parameter int unsigned NUM_CH = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start_i,
  input  logic                     frame_done_i,
  input  cmd_t                     cmd_i,
  input  logic [CODE_W-1:0]        code_i,
  input  logic                     ldac_fall_i,
  input  logic                     ldac_low_i,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o,
  output logic [NUM_CH-1:0]        pd_o
);
  localparam int unsigned CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [3:0]  NUM_CH_NIB = 4'(NUM_CH);

  logic [CODE_W-1:0] in_q  [NUM_CH];
  logic [CODE_W-1:0] dac_q [NUM_CH];
  logic [NUM_CH-1:0] pd_q;
  logic [NUM_CH-1:0] sel;
  logic              armed_q;

  always_comb begin
    sel = '0;
    if (cmd_i.ch == CH_ALL)          sel = '1;
    else if (cmd_i.ch < NUM_CH_NIB)  sel[cmd_i.ch[CH_IDX_W-1:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         armed_q <= 1'b0;
    else if (start_i)                   armed_q <= 1'b0;
    else if (frame_done_i)              armed_q <= 1'b1;
    else if (ldac_fall_i)               armed_q <= 1'b0;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        in_q[c]  <= '0;
        dac_q[c] <= '0;
        pd_q[c]  <= 1'b0;
      end else begin
        if (ldac_fall_i && armed_q) dac_q[c] <= in_q[c];
        if (frame_done_i && sel[c]) begin
          case (cmd_i.op)
            OP_WRITE:  in_q[c] <= code_i;
            OP_UPDATE: begin
              dac_q[c] <= in_q[c];
              pd_q[c]  <= 1'b0;
            end
            OP_WRUPD: begin
              in_q[c]  <= code_i;
              dac_q[c] <= code_i;
              pd_q[c]  <= 1'b0;
            end
            OP_PWRDN: if (!ldac_low_i) pd_q[c] <= 1'b1;
            default: ;
          endcase
        end
      end
    end

    assign dac_code_o[c*CODE_W +: CODE_W] = dac_q[c];
    assign pd_o[c] = pd_q[c] & ~ldac_low_i;

    // R6
    load_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ldac_fall_i && armed_q && !frame_done_i) |=> (dac_q[c] == $past(in_q[c])));

    // R7
    no_stray_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ldac_fall_i && !armed_q && !frame_done_i) |=> $stable(dac_q[c]));

    // R9
    pd_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_i && ldac_low_i && cmd_i.op == OP_PWRDN) |=> $stable(pd_q[c]));

    // R4
    wake_on_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done_i && sel[c] && (cmd_i.op == OP_UPDATE || cmd_i.op == OP_WRUPD)) |=> !pd_q[c]);
  end
endmodule

// File: rtl/dqf_front.sv
module dqf_front
  import dqf_pkg::*;
#(
  parameter int unsigned NUM_CH      = 4,
  parameter int unsigned ADDR_W      = 7,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [ADDR_W-1:0]        dev_addr,
  input  logic                     scl_i,
  input  logic                     sda_i,
  output logic                     sda_oe,
  input  logic                     ldac_n_i,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o,
  output logic [NUM_CH-1:0]        pwrdn_o
);
  logic       scl_s, sda_s, ldac_s, ldac_prev_q;
  logic       start, frame_done, ldac_fall;
  cmd_t       cmd;
  logic [CODE_W-1:0] code;

  dqf_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b111)) i_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({scl_i, sda_i, ldac_n_i}),
    .q     ({scl_s, sda_s, ldac_s})
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ldac_prev_q <= 1'b1;
    else        ldac_prev_q <= ldac_s;
  end
  assign ldac_fall = ldac_prev_q & ~ldac_s;

  dqf_i2c_rx #(.ADDR_W(ADDR_W)) i_rx (
    .clk          (clk),
    .rst_n        (rst_n),
    .dev_addr     (dev_addr),
    .scl_s        (scl_s),
    .sda_s        (sda_s),
    .sda_oe       (sda_oe),
    .start_o      (start),
    .frame_done_o (frame_done),
    .cmd_o        (cmd),
    .code_o       (code)
  );

  dqf_regbank #(.NUM_CH(NUM_CH)) i_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start),
    .frame_done_i (frame_done),
    .cmd_i        (cmd),
    .code_i       (code),
    .ldac_fall_i  (ldac_fall),
    .ldac_low_i   (~ldac_s),
    .dac_code_o   (dac_code_o),
    .pd_o         (pwrdn_o)
  );

  // R7
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && !ldac_fall) |=> $stable(dac_code_o));
endmodule

// File: tb/test_dqf_front.sv
module test_dqf_front;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 8;
  localparam logic [6:0] MY_ADDR = 7'h22;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1, ldac_n = 1'b1;
  logic sda_oe, sda_line;
  logic [47:0] dac_code_o;
  logic [3:0]  pwrdn_o;

  assign sda_line = sda_m & ~sda_oe;

  dqf_front i_dqf_front (
    .clk(clk), .rst_n(rst_n), .dev_addr(MY_ADDR),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .ldac_n_i(ldac_n), .dac_code_o(dac_code_o), .pwrdn_o(pwrdn_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_cmp = 0, n_bad = 0, oe_leak = 0;
  logic [11:0] in_m [4];
  logic [11:0] dac_m [4];
  logic [3:0]  pd_m = 4'h0;
  bit armed_m = 0, ldac_low_m = 0;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic [47:0] act, input logic [47:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_outputs(input string req);
    for (int c = 0; c < 4; c++)
      chk(req, $sformatf("code ch%0d", c), 48'(dac_code_o[c*12 +: 12]), 48'(dac_m[c]));
    chk(req, "pwrdn", 48'(pwrdn_o), 48'(ldac_low_m ? 4'h0 : pd_m));
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
    armed_m = 0;
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      if (sda_oe) oe_leak++;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    acked = !sda_line;
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_frame(input logic [6:0] a, input bit rd, input logic [7:0] cmd,
                            input logic [11:0] code, input logic [3:0] junk,
                            input int nbytes, output logic [4:0] acks);
    logic [7:0] bytes [5];
    bit ak;
    bytes[0] = {a, rd};
    bytes[1] = cmd;
    bytes[2] = code[11:4];
    bytes[3] = {code[3:0], junk};
    bytes[4] = 8'h5C;
    acks = '0;
    bus_start();
    for (int i = 0; i < nbytes; i++) begin
      put_byte(bytes[i], ak);
      acks[i] = ak;
    end
    bus_stop();
    tick(Q);
  endtask

  task automatic model_apply(input logic [7:0] cmd, input logic [11:0] code);
    logic [3:0] sel;
    if (cmd[3:0] == 4'hF)     sel = 4'hF;
    else if (cmd[3:0] < 4'd4) sel = 4'(1 << cmd[1:0]);
    else                      sel = 4'h0;
    for (int c = 0; c < 4; c++) begin
      if (sel[c]) begin
        case (cmd[7:4])
          4'h0: in_m[c] = code;
          4'h1: begin dac_m[c] = in_m[c]; pd_m[c] = 1'b0; end
          4'h3: begin in_m[c] = code; dac_m[c] = code; pd_m[c] = 1'b0; end
          4'h4: if (!ldac_low_m) pd_m[c] = 1'b1;
          default: ;
        endcase
      end
    end
    armed_m = 1;
  endtask

  task automatic good_write(input string req, input logic [7:0] cmd, input logic [11:0] code, input logic [3:0] junk);
    logic [4:0] acks;
    send_frame(MY_ADDR, 1'b0, cmd, code, junk, 4, acks);
    chk(req, "acks", 48'(acks[3:0]), 48'h0F);
    model_apply(cmd, code);
    chk_outputs(req);
  endtask

  task automatic ldac_drop();
    ldac_n = 1'b0;
    ldac_low_m = 1;
    if (armed_m) begin
      for (int c = 0; c < 4; c++) dac_m[c] = in_m[c];
      armed_m = 0;
    end
    tick(Q);
  endtask

  task automatic ldac_raise();
    ldac_n = 1'b1;
    ldac_low_m = 0;
    tick(Q);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [4:0] acks;
    logic [3:0] ops [6];
    logic [3:0] chs [7];
    int k;
    ops[0] = 4'h0; ops[1] = 4'h1; ops[2] = 4'h3; ops[3] = 4'h4; ops[4] = 4'h2; ops[5] = 4'hF;
    chs[0] = 4'h0; chs[1] = 4'h1; chs[2] = 4'h2; chs[3] = 4'h3; chs[4] = 4'hF; chs[5] = 4'h4; chs[6] = 4'h9;
    for (int c = 0; c < 4; c++) begin in_m[c] = '0; dac_m[c] = '0; end

    tick(4);
    rst_n = 1'b1;
    tick(4);
    // R10 reset state
    chk_outputs("R10");
    chk("R10", "sda_oe", 48'(sda_oe), 48'h0);

    // R2/R3 sweep of operations and channel selections, junk in the low nibble
    k = 0;
    for (int o = 0; o < 6; o++) begin
      for (int h = 0; h < 7; h++) begin
        good_write("R3", {ops[o], chs[h]}, 12'(k * 12'h5A3 + 12'h0F1), 4'(k) ^ 4'hA);
        k++;
      end
    end
    // R5 no enable during data bits
    chk("R5", "sda_oe during data bits", 48'(oe_leak), 48'h0);

    // R4 power down all, then update ch2 and write-update ch0
    good_write("R4", 8'h4F, 12'h111, 4'h0);
    good_write("R4", 8'h12, 12'h000, 4'h0);
    good_write("R4", 8'h30, 12'hABC, 4'h5);

    // R1 wrong address and read bit
    send_frame(MY_ADDR ^ 7'h01, 1'b0, 8'h3F, 12'h777, 4'h0, 4, acks);
    chk("R1", "acks wrong address", 48'(acks[3:0]), 48'h0);
    chk_outputs("R1");
    send_frame(MY_ADDR, 1'b1, 8'h3F, 12'h777, 4'h0, 4, acks);
    chk("R1", "acks read bit", 48'(acks[3:0]), 48'h0);
    chk_outputs("R1");

    // R2 fifth byte not acknowledged
    send_frame(MY_ADDR, 1'b0, 8'h01, 12'h9E4, 4'h3, 5, acks);
    chk("R2", "acks with fifth byte", 48'(acks), 48'h0F);
    model_apply(8'h01, 12'h9E4);
    chk_outputs("R2");

    // R6 load after complete write
    good_write("R6", 8'h03, 12'h3C5, 4'h0);
    ldac_drop();
    chk_outputs("R6");
    ldac_raise();

    // R7 complete write, then partial transfer, then load
    good_write("R7", 8'h01, 12'h6D2, 4'h0);
    send_frame(MY_ADDR, 1'b0, 8'h02, 12'h000, 4'h0, 2, acks);
    ldac_drop();
    chk_outputs("R7");
    chk("R7", "dac ch1 kept", 48'(dac_code_o[12 +: 12]), 48'(dac_m[1]));
    ldac_raise();
    ldac_drop();
    chk_outputs("R7");
    ldac_raise();

    // R8 forced power-up while pin is low
    good_write("R8", 8'h43, 12'h000, 4'h0);
    ldac_drop();
    chk("R8", "pwrdn low pin", 48'(pwrdn_o), 48'h0);
    chk_outputs("R8");

    // R9 power-down refused while pin is low
    good_write("R9", 8'h4F, 12'h000, 4'h0);
    ldac_raise();
    chk("R9", "pwrdn after release", 48'(pwrdn_o), 48'(pd_m));
    chk_outputs("R9");

    finish_run();
  end
endmodule